// File: doc/BRIEF.md
# Serial Video Receive Mode Search Controller

This block decides which serial video rate the receiver is set up for. In automatic operation it steps through a list of six candidate rates: HD, SD, 3G, 6G, 12G at the integer rate and 12G at the 1/1.001 rate. A unary enable mask limits the search to a subset of that list. Each candidate is held for a fixed number of enabled clocks. The first candidate for which the downstream framing detector raises its qualifier becomes the locked mode. If the qualifier then stays low for too long, the lock is dropped and the search resumes from the next enabled candidate.

When automatic detection is turned off, the block passes a forced mode straight to its mode output and holds the locked flag high. A synchronous search reset, qualified by the clock enable, returns only the search state to its start point. Decoded indicators report the locked rate to the rest of the receiver. A single 12G indicator covers both 12G rates.

Top module: `sdi_mode_hunt`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, with `auto_en` high, `mode_o` is 000 (HD), `locked_o` is low and all five indicators are low.
- R2: `mode_o` encodes the current candidate as follows: HD=000, SD=001, 3G=010, 6G=100, 12G integer=101, 12G 1/1.001=110. The candidate order is HD, SD, 3G, 6G, 12G integer, 12G 1/1.001, and `mode_mask` bits 0 to 5 enable the candidates in that same order.
- R3: The block never locks on a candidate whose mask bit is low. If the current candidate is masked, the block leaves it on the next enabled clock for the next enabled candidate.
- R4: While searching, an enabled candidate is held for `DWELL` enabled clocks with the qualifier low. The block then moves to the next enabled candidate, and the search wraps from the end of the list back to its start.
- R5: While searching, a high `cand_ok` on an enabled clock, with an enabled candidate, raises `locked_o` after that edge and keeps `mode_o` unchanged.
- R6: Once locked, `LOSS_LIMIT` consecutive enabled clocks with `cand_ok` low drop `locked_o` and move to the next enabled candidate. Any enabled clock with `cand_ok` high restarts that count.
- R7: With `auto_en` low, `mode_o` equals `forced_mode` and `locked_o` is high. Any enabled clock in this state returns the search to HD, unlocked.
- R8: `hunt_rst` resets the search to HD, unlocked, only on a clock edge where `ce` is also high. When `ce` is low, `hunt_rst` has no effect.
- R9: On a clock edge where `ce` is low, the search state (mode and lock) does not change.
- R10: The indicators are each high only when `locked_o` is high: `ind_hd` for 000, `ind_sd` for 001, `ind_3g` for 010, `ind_6g` for 100, and `ind_12g` for 101 or 110. Codes 011 and 111 light no indicator.
- R11: With `mode_mask` all zeros and `auto_en` high, the block stays on HD with `locked_o` low, whatever `cand_ok` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for all search state |
| hunt_rst | input | 1 | Synchronous search reset, acts only with `ce` high |
| mode_mask | input | 6 | Unary enable, one bit per candidate mode |
| auto_en | input | 1 | High selects automatic search, low selects forced mode |
| forced_mode | input | 3 | Mode driven out when `auto_en` is low |
| cand_ok | input | 1 | Framing detector reports valid data for the current candidate |
| mode_o | output | 3 | Current mode code |
| locked_o | output | 1 | Search has settled (forced high when `auto_en` is low) |
| ind_hd | output | 1 | Locked in HD |
| ind_sd | output | 1 | Locked in SD |
| ind_3g | output | 1 | Locked in 3G |
| ind_6g | output | 1 | Locked in 6G |
| ind_12g | output | 1 | Locked in either 12G rate |

## Verification
The key collisions are cases where two actions fall on the same enabled edge. One is a qualifier arriving on the last edge of a dwell, where the lock must win over the advance. Another is a search reset, a forced-mode switch or a mask change landing on the edge where the loss count expires. The bench uses a short dwell and a short loss limit so that random `ce`, `hunt_rst`, mask and qualifier patterns hit these coincidences often. Every cycle it compares the mode, the lock flag and the indicators against a bench model built from the priority order in the requirements: reset sources first, then masked-candidate skip, then the lock or loss logic, then the dwell.

// File: rtl/sdi_hunt_pkg.sv
package sdi_hunt_pkg;

  localparam int NUM_MODES = 6;
  localparam int MODE_W    = 3;
  localparam int IDX_W     = $clog2(NUM_MODES);

  typedef enum logic [MODE_W-1:0] {
    MD_HD     = 3'b000,
    MD_SD     = 3'b001,
    MD_3G     = 3'b010,
    MD_6G     = 3'b100,
    MD_12G    = 3'b101,
    MD_12G_FR = 3'b110
  } mode_e;

  // Candidate index to mode code; index order matches the mask bit order.
  function automatic logic [MODE_W-1:0] mode_of_idx(input logic [IDX_W-1:0] idx);
    logic [MODE_W-1:0] code;
    case (idx)
      3'd0:    code = MD_HD;
      3'd1:    code = MD_SD;
      3'd2:    code = MD_3G;
      3'd3:    code = MD_6G;
      3'd4:    code = MD_12G;
      3'd5:    code = MD_12G_FR;
      default: code = MD_HD;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/sdi_hunt_pick.sv
module sdi_hunt_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] cur,
  output logic [IW-1:0] nxt,
  output logic          any_o
);

  // Lowest positive offset from cur (with wrap) whose mask bit is set.
  always_comb begin
    nxt = (mask[cur]) ? cur : '0;
    for (int k = N - 1; k >= 1; k--) begin
      int j;
      j = (int'(cur) + k) % N;
      if (mask[j]) nxt = IW'(j);
    end
  end

  assign any_o = |mask;

endmodule

// File: rtl/sdi_hunt_timer.sv
module sdi_hunt_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == W'(LIMIT - 1));

  // The owner never increments past the terminal count (dwell/loss windows).
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) <= LIMIT - 1));

endmodule

// File: rtl/sdi_hunt_flags.sv
module sdi_hunt_flags
  import sdi_hunt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              locked,
  output logic              ind_hd,
  output logic              ind_sd,
  output logic              ind_3g,
  output logic              ind_6g,
  output logic              ind_12g
);

  always_comb begin
    ind_hd  = locked && (mode == MD_HD);
    ind_sd  = locked && (mode == MD_SD);
    ind_3g  = locked && (mode == MD_3G);
    ind_6g  = locked && (mode == MD_6G);
    ind_12g = locked && ((mode == MD_12G) || (mode == MD_12G_FR));
  end

  assert_ind_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ind_hd, ind_sd, ind_3g, ind_6g, ind_12g}));

endmodule

// File: rtl/sdi_mode_hunt.sv
module sdi_mode_hunt
  import sdi_hunt_pkg::*;
#(
  parameter int DWELL      = 16,
  parameter int LOSS_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              hunt_rst,
  input  logic [NUM_MODES-1:0] mode_mask,
  input  logic              auto_en,
  input  logic [MODE_W-1:0] forced_mode,
  input  logic              cand_ok,
  output logic [MODE_W-1:0] mode_o,
  output logic              locked_o,
  output logic              ind_hd,
  output logic              ind_sd,
  output logic              ind_3g,
  output logic              ind_6g,
  output logic              ind_12g
);

  logic [IDX_W-1:0] idx_q, idx_d, idx_nxt;
  logic             lock_q, lock_d;
  logic             any_en;
  logic             dw_clr, dw_inc, dw_done;
  logic             ms_clr, ms_inc, ms_done;

  sdi_hunt_pick #(.N(NUM_MODES), .IW(IDX_W)) u_pick (
    .mask  (mode_mask),
    .cur   (idx_q),
    .nxt   (idx_nxt),
    .any_o (any_en)
  );

  sdi_hunt_timer #(.LIMIT(DWELL)) u_dwell (
    .clk (clk), .rst_n (rst_n), .clr (dw_clr), .inc (dw_inc), .done (dw_done)
  );

  sdi_hunt_timer #(.LIMIT(LOSS_LIMIT)) u_loss (
    .clk (clk), .rst_n (rst_n), .clr (ms_clr), .inc (ms_inc), .done (ms_done)
  );

  // Next-state: reset sources, masked skip, locked watch, then search dwell.
  always_comb begin
    idx_d  = idx_q;
    lock_d = lock_q;
    dw_clr = 1'b0;
    dw_inc = 1'b0;
    ms_clr = 1'b0;
    ms_inc = 1'b0;
    if (ce) begin
      if (!auto_en || hunt_rst || !any_en) begin
        idx_d  = '0;
        lock_d = 1'b0;
        dw_clr = 1'b1;
        ms_clr = 1'b1;
      end else if (!mode_mask[idx_q]) begin
        idx_d  = idx_nxt;
        lock_d = 1'b0;
        dw_clr = 1'b1;
        ms_clr = 1'b1;
      end else if (lock_q) begin
        if (cand_ok) begin
          ms_clr = 1'b1;
        end else if (ms_done) begin
          idx_d  = idx_nxt;
          lock_d = 1'b0;
          dw_clr = 1'b1;
          ms_clr = 1'b1;
        end else begin
          ms_inc = 1'b1;
        end
      end else begin
        if (cand_ok) begin
          lock_d = 1'b1;
          dw_clr = 1'b1;
          ms_clr = 1'b1;
        end else if (dw_done) begin
          idx_d  = idx_nxt;
          dw_clr = 1'b1;
        end else begin
          dw_inc = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      lock_q <= lock_d;
    end
  end

  assign mode_o   = auto_en ? mode_of_idx(idx_q) : forced_mode;
  assign locked_o = !auto_en || lock_q;

  sdi_hunt_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_o),
    .locked  (locked_o),
    .ind_hd  (ind_hd),
    .ind_sd  (ind_sd),
    .ind_3g  (ind_3g),
    .ind_6g  (ind_6g),
    .ind_12g (ind_12g)
  );

  assert_hold_no_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(idx_q) && $stable(lock_q)));

  assert_no_masked_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(mode_mask[idx_q]));

  assert_hunt_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && hunt_rst) |=> (!lock_q && idx_q == '0));

  assert_forced_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !auto_en) |=> (!lock_q && idx_q == '0));

  assert_empty_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && auto_en && mode_mask == '0) |=> (!lock_q && idx_q == '0));

  assert_ind_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_hd || ind_sd || ind_3g || ind_6g || ind_12g) |-> locked_o);

endmodule

// File: tb/sdi_mode_hunt_bench.sv
`timescale 1ns/1ps
module sdi_mode_hunt_bench;

  localparam int DW = 12;
  localparam int LL = 3;

  logic       clk = 1'b0;
  logic       rst_n, ce, hunt_rst, auto_en, cand_ok;
  logic [5:0] mode_mask;
  logic [2:0] forced_mode;
  logic [2:0] mode_o;
  logic       locked_o, ind_hd, ind_sd, ind_3g, ind_6g, ind_12g;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  sdi_mode_hunt #(.DWELL(DW), .LOSS_LIMIT(LL)) u_sdi_mode_hunt (
    .clk (clk), .rst_n (rst_n), .ce (ce), .hunt_rst (hunt_rst),
    .mode_mask (mode_mask), .auto_en (auto_en), .forced_mode (forced_mode),
    .cand_ok (cand_ok), .mode_o (mode_o), .locked_o (locked_o),
    .ind_hd (ind_hd), .ind_sd (ind_sd), .ind_3g (ind_3g),
    .ind_6g (ind_6g), .ind_12g (ind_12g)
  );

  function automatic logic [2:0] code_of(int i);
    case (i)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b010;
      3: return 3'b100; 4: return 3'b101; 5: return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int next_en(logic [5:0] m, int cur);
    for (int k = 1; k < 6; k++) if (m[(cur + k) % 6]) return (cur + k) % 6;
    return m[cur] ? cur : 0;
  endfunction

  function automatic logic [4:0] ind_of(logic [2:0] md, logic lk);
    if (!lk) return 5'b0;
    case (md)
      3'b000: return 5'b10000;
      3'b001: return 5'b01000;
      3'b010: return 5'b00100;
      3'b100: return 5'b00010;
      3'b101, 3'b110: return 5'b00001;
      default: return 5'b0;
    endcase
  endfunction

  // Bench model of the search state, from the requirement priorities.
  int m_idx, m_dw, m_ms;
  bit m_lock;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_lock = 0; m_dw = 0; m_ms = 0;
    end else if (ce) begin
      if (!auto_en || hunt_rst || mode_mask == 6'b0) begin
        m_idx = 0; m_lock = 0; m_dw = 0; m_ms = 0;
      end else if (!mode_mask[m_idx]) begin
        m_idx = next_en(mode_mask, m_idx); m_lock = 0; m_dw = 0; m_ms = 0;
      end else if (m_lock) begin
        if (cand_ok) m_ms = 0;
        else if (m_ms == LL - 1) begin
          m_idx = next_en(mode_mask, m_idx); m_lock = 0; m_dw = 0; m_ms = 0;
        end else m_ms++;
      end else begin
        if (cand_ok) begin m_lock = 1; m_dw = 0; m_ms = 0; end
        else if (m_dw == DW - 1) begin m_idx = next_en(mode_mask, m_idx); m_dw = 0; end
        else m_dw++;
      end
    end
  end

  function automatic logic [2:0] exp_mode();
    return auto_en ? code_of(m_idx) : forced_mode;
  endfunction
  function automatic logic exp_lock();
    return !auto_en || m_lock;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    chk(tag, {5'b0, mode_o}, {5'b0, exp_mode()}, "mode");
    chk(tag, {7'b0, locked_o}, {7'b0, exp_lock()}, "locked");
    chk(tag, {3'b0, ind_hd, ind_sd, ind_3g, ind_6g, ind_12g},
        {3'b0, ind_of(exp_mode(), exp_lock())}, "indicators");
  endtask

  task automatic expect_out(string req, logic [2:0] md, logic lk, logic [4:0] ind);
    chk(req, {5'b0, mode_o}, {5'b0, md}, "mode(directed)");
    chk(req, {7'b0, locked_o}, {7'b0, lk}, "locked(directed)");
    chk(req, {3'b0, ind_hd, ind_sd, ind_3g, ind_6g, ind_12g}, {3'b0, ind}, "ind(directed)");
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) compare_model();
  endtask

  // Drive cand_ok high only while the expected mode equals the target.
  task automatic hunt_for(logic [2:0] target, int n);
    for (int i = 0; i < n; i++) begin
      cand_ok = auto_en && (exp_mode() == target);
      tick();
    end
    cand_ok = 0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd1337));
    rst_n = 0; ce = 1; hunt_rst = 0; auto_en = 1; cand_ok = 0;
    mode_mask = 6'b000110; forced_mode = 3'b000;
    repeat (3) @(negedge clk);
    tag = "R1";
    expect_out("R1", 3'b000, 1'b0, 5'b0);
    rst_n = 1;

    // R3: HD is masked and is left on the first enabled edge.
    tag = "R3"; tick();
    expect_out("R3", 3'b001, 1'b0, 5'b0);
    // R4: dwell then advance, then wrap.
    tag = "R4";
    repeat (DW) tick();
    expect_out("R4", 3'b010, 1'b0, 5'b0);
    repeat (DW) tick();
    expect_out("R4", 3'b001, 1'b0, 5'b0);

    // R5: lock on 3G.
    tag = "R5"; mode_mask = 6'b000111;
    hunt_for(3'b010, 40);
    expect_out("R5", 3'b010, 1'b1, 5'b00100);

    // R6: misses below the limit, a refresh, then the full loss window.
    tag = "R6";
    cand_ok = 0; repeat (LL - 1) tick();
    expect_out("R6", 3'b010, 1'b1, 5'b00100);
    cand_ok = 1; tick();
    cand_ok = 0; repeat (LL - 1) tick();
    expect_out("R6", 3'b010, 1'b1, 5'b00100);
    tick();
    expect_out("R6", 3'b000, 1'b0, 5'b0);

    // R9: lock SD, then hold state with ce low.
    tag = "R9";
    hunt_for(3'b001, 40);
    ce = 0; cand_ok = 0; repeat (10) tick();
    expect_out("R9", 3'b001, 1'b1, 5'b01000);

    // R8: hunt_rst ignored without ce, acts with ce.
    tag = "R8"; hunt_rst = 1; repeat (3) tick();
    expect_out("R8", 3'b001, 1'b1, 5'b01000);
    ce = 1; cand_ok = 1; tick();
    expect_out("R8", 3'b000, 1'b0, 5'b0);
    hunt_rst = 0; cand_ok = 0;

    // R7 and R10: forced modes, all eight codes.
    tag = "R7"; auto_en = 0;
    for (int c = 0; c < 8; c++) begin
      forced_mode = 3'(c);
      #1;
      expect_out("R7", 3'(c), 1'b1, ind_of(3'(c), 1'b1));
      tag = "R10"; tick(); tag = "R7";
    end
    auto_en = 1; tick();
    expect_out("R7", 3'b000, 1'b0, 5'b0);

    // R11: empty mask never locks.
    tag = "R11"; mode_mask = 6'b0; cand_ok = 1;
    repeat (30) tick();
    expect_out("R11", 3'b000, 1'b0, 5'b0);
    cand_ok = 0;

    // R2: every code reachable with the full mask.
    tag = "R2"; mode_mask = 6'b111111;
    for (int i = 0; i < 6; i++) begin
      hunt_rst = 1; tick(); hunt_rst = 0;
      hunt_for(code_of(i), 6 * DW + 4);
      expect_out("R2", code_of(i), 1'b1, ind_of(code_of(i), 1'b1));
    end

    // Random mix; collisions of dwell, loss, reset and mask changes.
    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      ce       = ($urandom_range(0, 9) < 8);
      hunt_rst = ($urandom_range(0, 99) < 2);
      if ($urandom_range(0, 199) == 0) auto_en = ~auto_en;
      if ($urandom_range(0, 149) == 0) mode_mask = 6'($urandom_range(0, 63));
      forced_mode = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0)
        cand_ok = (exp_mode() == 3'b100) || (exp_mode() == 3'b110);
      else
        cand_ok = ($urandom_range(0, 19) == 0) || (m_lock && $urandom_range(0, 1) == 1);
      tick();
    end

    finish_up();
  end

endmodule